// File: doc/BRIEF.md
# I2C Master Repeated-Start Sequencer

This block produces an I2C repeated-start condition on open-drain SDA and SCL lines for a controller that is the only master on its bus. A command write with the request bit set, made while both the sequencer and the rest of the controller are idle, starts a fixed series of phases. SCL is pulled low, SDA is let go, SCL is let go, both lines are held high, and finally SDA is pulled low while SCL stays high. Each phase is timed by a reloadable baud down-counter. Each phase also waits for the sampled line level before it starts its timer, so a slow or stretched line only lengthens the phase and never shortens it.

When the sequence ends, the request bit clears by itself and a completion interrupt flag sets. SDA is left driven low for the address byte that follows. A separate detector watches the lines and sets a start-seen status bit whenever SDA falls while SCL is high. While the sequence runs, the block refuses other command writes and refuses writes to the transmit buffer; a refused buffer write sets a write-collision flag. If another device disturbs the lines, the block sets a bus-collision flag, lets go of both lines and returns to idle. The line drivers are active-high drive-low enables, and the outside world provides the wired-AND.

Top module: `i2c_rs_top`

## Requirements
- R1: A command write (`cmd_we`) whose request bit `cmd_wdata[1]` is 1 starts a sequence only when the sequencer is idle and `bus_idle` is 1. Otherwise the request has no effect: `scl_drive_low` stays 0 and `cmd_bits[1]` stays 0.
- R2: After the accepting write is captured, `scl_drive_low` is 1 on the next cycle. One cycle after `scl_in` is sampled low, SDA is released and the baud counter starts.
- R3: SCL is released only once the SDA-released timer has run out and `sda_in` is sampled high. With reload value N, SCL is released N+2 cycles after it was first driven low.
- R4: After `scl_in` is sampled high, both lines are left high for a baud period, then `sda_drive_low` goes to 1. This happens N+2 cycles after SCL is released.
- R5: SDA is held low for one more baud period (N+1 cycles). Then `cmd_bits[1]` clears, `done_irq` sets, `sda_drive_low` stays 1 and `scl_drive_low` stays 0.
- R6: A reload value of N gives a baud period of N+1 clocks. N = 0 gives a period of one clock.
- R7: `start_seen` sets one cycle after the sampled lines show SDA falling while SCL stays high. It does not set before SDA is driven low in the sequence.
- R8: A transmit-buffer write (`buf_we`) while the sequence runs sets `wcol` and leaves `buf_data` unchanged. A write while idle loads `buf_data`.
- R9: Command writes while the sequence runs are ignored and leave all five `cmd_bits` as they were. A write while idle stores the five bits, with bit 1 set only when the request is accepted.
- R10: If `sda_in` is low when `scl_in` is sampled high after SCL is released, `bcol` sets on the next cycle.
- R11: If `scl_in` goes low during the both-high phase, `bcol` sets. On any bus collision, both drive enables go to 0, `cmd_bits[1]` clears, the sequencer returns to idle and `done_irq` does not set.
- R12: `done_irq`, `wcol`, `bcol` and `start_seen` stay set until a cycle with `flag_clr` high, which clears all four.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_we | input | 1 | Command register write strobe |
| cmd_wdata | input | 5 | Command write data; bit 1 is the repeated-start request |
| reload | input | 7 | Baud counter reload value N (period N+1 clocks) |
| bus_idle | input | 1 | High when no other controller event is in progress |
| sda_in | input | 1 | Sampled SDA line level |
| scl_in | input | 1 | Sampled SCL line level |
| buf_we | input | 1 | Transmit buffer write strobe |
| buf_wdata | input | 8 | Transmit buffer write data |
| flag_clr | input | 1 | Clears done_irq, wcol, bcol and start_seen |
| sda_drive_low | output | 1 | Drive SDA low when 1 |
| scl_drive_low | output | 1 | Drive SCL low when 1 |
| cmd_bits | output | 5 | Command register contents; bit 1 clears itself |
| start_seen | output | 1 | A start condition was seen on the lines |
| done_irq | output | 1 | Repeated start completed |
| wcol | output | 1 | Buffer write refused during the sequence |
| bcol | output | 1 | Bus collision detected |
| buf_data | output | 8 | Transmit buffer contents |

## Verification
The checker tests these rules on every cycle: SCL is only ever released with SDA high, SDA is only pulled low while SCL is high, the SCL drive only begins on an accepted request, the command and buffer contents stay frozen under busy writes, and completion or collision leaves the lines and the request bit in the required state. The exact phase lengths for a given reload value can only be shown by the bench's scenarios, which measure the cycle distances between the line edges and the interrupt. The same holds for the two collision cases, which need a second master on the wires, and for the start-seen timing.

// File: rtl/i2c_rs_pkg.sv
package i2c_rs_pkg;

    localparam int CMD_W   = 5;
    localparam int REQ_BIT = 1;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_PULL_SCL = 3'd1,
        ST_SDA_REL  = 3'd2,
        ST_SCL_WAIT = 3'd3,
        ST_SETUP    = 3'd4,
        ST_HOLD     = 3'd5
    } rs_state_e;

endpackage

// File: rtl/i2c_rs_baud.sv
// Reloadable baud down-counter: a load of N gives done again after N+1 clocks.
module i2c_rs_baud #(
    parameter int RELOAD_W = 7
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load_i,
    input  logic [RELOAD_W-1:0] reload_i,
    output logic                done_o
);

    typedef struct packed {
        logic                run;
        logic [RELOAD_W-1:0] cnt;
    } baud_t;

    baud_t b_d, b_q;

    always_comb begin
        b_d = b_q;
        if (load_i) begin
            b_d.run = 1'b1;
            b_d.cnt = reload_i;
        end else if (b_q.run) begin
            if (b_q.cnt == '0) begin
                b_d.run = 1'b0;
            end else begin
                b_d.cnt = b_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            b_q <= '0;
        end else begin
            b_q <= b_d;
        end
    end

    assign done_o = !b_q.run || (b_q.cnt == '0);

endmodule

// File: rtl/i2c_rs_linemon.sv
// Watches the sampled lines and flags SDA falling while SCL is held high.
module i2c_rs_linemon (
    input  logic clk,
    input  logic rst_n,
    input  logic sda_i,
    input  logic scl_i,
    output logic start_o
);

    typedef struct packed {
        logic sda;
        logic scl;
    } lines_t;

    lines_t l_d, l_q;

    always_comb begin
        l_d.sda = sda_i;
        l_d.scl = scl_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            l_q <= '1;
        end else begin
            l_q <= l_d;
        end
    end

    assign start_o = l_q.sda && l_q.scl && !sda_i && scl_i;

endmodule

// File: rtl/i2c_rs_top.sv
module i2c_rs_top #(
    parameter int RELOAD_W = 7,
    parameter int DATA_W   = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         cmd_we,
    input  logic [i2c_rs_pkg::CMD_W-1:0] cmd_wdata,
    input  logic [RELOAD_W-1:0]          reload,
    input  logic                         bus_idle,
    input  logic                         sda_in,
    input  logic                         scl_in,
    input  logic                         buf_we,
    input  logic [DATA_W-1:0]            buf_wdata,
    input  logic                         flag_clr,
    output logic                         sda_drive_low,
    output logic                         scl_drive_low,
    output logic [i2c_rs_pkg::CMD_W-1:0] cmd_bits,
    output logic                         start_seen,
    output logic                         done_irq,
    output logic                         wcol,
    output logic                         bcol,
    output logic [DATA_W-1:0]            buf_data
);

    import i2c_rs_pkg::*;

    typedef struct packed {
        rs_state_e         state;
        logic              scl_low;
        logic              sda_low;
        logic [CMD_W-1:0]  cmd;
        logic              start_seen;
        logic              irq;
        logic              wcol;
        logic              bcol;
        logic [DATA_W-1:0] buf_data;
    } regs_t;

    regs_t r_d, r_q;

    logic tmr_load;
    logic tmr_done;
    logic line_start;
    logic busy;
    logic req_ok;

    i2c_rs_baud #(
        .RELOAD_W (RELOAD_W)
    ) u_baud (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (tmr_load),
        .reload_i (reload),
        .done_o   (tmr_done)
    );

    i2c_rs_linemon u_mon (
        .clk     (clk),
        .rst_n   (rst_n),
        .sda_i   (sda_in),
        .scl_i   (scl_in),
        .start_o (line_start)
    );

    assign busy   = (r_q.state != ST_IDLE);
    assign req_ok = cmd_we && cmd_wdata[REQ_BIT] && bus_idle && !busy;

    always_comb begin
        r_d      = r_q;
        tmr_load = 1'b0;

        // sticky flags: clear first so a same-cycle set wins
        if (flag_clr) begin
            r_d.irq        = 1'b0;
            r_d.wcol       = 1'b0;
            r_d.bcol       = 1'b0;
            r_d.start_seen = 1'b0;
        end
        if (line_start) begin
            r_d.start_seen = 1'b1;
        end

        // transmit buffer: refused while the sequence owns the bus
        if (buf_we) begin
            if (busy) begin
                r_d.wcol = 1'b1;
            end else begin
                r_d.buf_data = buf_wdata;
            end
        end

        unique case (r_q.state)
            ST_IDLE: begin
                if (cmd_we) begin
                    r_d.cmd          = cmd_wdata;
                    r_d.cmd[REQ_BIT] = req_ok;
                end
                if (req_ok) begin
                    r_d.scl_low = 1'b1;
                    r_d.state   = ST_PULL_SCL;
                end
            end
            ST_PULL_SCL: begin
                if (!scl_in) begin
                    r_d.sda_low = 1'b0;
                    tmr_load    = 1'b1;
                    r_d.state   = ST_SDA_REL;
                end
            end
            ST_SDA_REL: begin
                if (tmr_done && sda_in) begin
                    r_d.scl_low = 1'b0;
                    r_d.state   = ST_SCL_WAIT;
                end
            end
            ST_SCL_WAIT: begin
                if (scl_in) begin
                    if (!sda_in) begin
                        r_d.bcol         = 1'b1;
                        r_d.scl_low      = 1'b0;
                        r_d.sda_low      = 1'b0;
                        r_d.cmd[REQ_BIT] = 1'b0;
                        r_d.state        = ST_IDLE;
                    end else begin
                        tmr_load  = 1'b1;
                        r_d.state = ST_SETUP;
                    end
                end
            end
            ST_SETUP: begin
                if (!scl_in) begin
                    r_d.bcol         = 1'b1;
                    r_d.scl_low      = 1'b0;
                    r_d.sda_low      = 1'b0;
                    r_d.cmd[REQ_BIT] = 1'b0;
                    r_d.state        = ST_IDLE;
                end else if (tmr_done) begin
                    r_d.sda_low = 1'b1;
                    tmr_load    = 1'b1;
                    r_d.state   = ST_HOLD;
                end
            end
            ST_HOLD: begin
                if (tmr_done) begin
                    r_d.cmd[REQ_BIT] = 1'b0;
                    r_d.irq          = 1'b1;
                    r_d.state        = ST_IDLE;
                end
            end
            default: begin
                r_d.state = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.state <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign sda_drive_low = r_q.sda_low;
    assign scl_drive_low = r_q.scl_low;
    assign cmd_bits      = r_q.cmd;
    assign start_seen    = r_q.start_seen;
    assign done_irq      = r_q.irq;
    assign wcol          = r_q.wcol;
    assign bcol          = r_q.bcol;
    assign buf_data      = r_q.buf_data;

endmodule

// File: rtl/i2c_rs_checker.sv
module i2c_rs_checker #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_we,
    input logic [4:0]        cmd_wdata,
    input logic              bus_idle,
    input logic              sda_in,
    input logic              scl_in,
    input logic              buf_we,
    input logic              busy,
    input logic              sda_drive_low,
    input logic              scl_drive_low,
    input logic [4:0]        cmd_bits,
    input logic              done_irq,
    input logic              wcol,
    input logic              bcol,
    input logic [DATA_W-1:0] buf_data
);

    assert_scl_only_on_request_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(scl_drive_low) |-> $past(cmd_we && cmd_wdata[1] && bus_idle && !busy));

    assert_scl_release_sda_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(scl_drive_low) |-> $past(sda_in));

    assert_sda_low_under_scl_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_drive_low) |-> $past(scl_in) && !scl_drive_low);

    assert_done_leaves_sda_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_irq) |-> sda_drive_low && !scl_drive_low && !cmd_bits[1] && !busy);

    assert_busy_buffer_write_refused_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(buf_we && busy) |-> wcol && $stable(buf_data));

    assert_busy_cmd_write_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cmd_we && busy) |-> (cmd_bits[4:2] == $past(cmd_bits[4:2])) && (cmd_bits[0] == $past(cmd_bits[0])));

    assert_collision_releases_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bcol) |-> !scl_drive_low && !sda_drive_low && !cmd_bits[1] && !busy);

endmodule

bind i2c_rs_top i2c_rs_checker #(.DATA_W(DATA_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cmd_we        (cmd_we),
    .cmd_wdata     (cmd_wdata),
    .bus_idle      (bus_idle),
    .sda_in        (sda_in),
    .scl_in        (scl_in),
    .buf_we        (buf_we),
    .busy          (busy),
    .sda_drive_low (sda_drive_low),
    .scl_drive_low (scl_drive_low),
    .cmd_bits      (cmd_bits),
    .done_irq      (done_irq),
    .wcol          (wcol),
    .bcol          (bcol),
    .buf_data      (buf_data)
);

// File: tb/test_i2c_rs_top.sv
`timescale 1ns/1ps
module test_i2c_rs_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_we = 1'b0;
    logic [4:0] cmd_wdata = '0;
    logic [6:0] reload = '0;
    logic       bus_idle = 1'b1;
    logic       buf_we = 1'b0;
    logic [7:0] buf_wdata = '0;
    logic       flag_clr = 1'b0;
    logic       inj_sda = 1'b0;
    logic       inj_scl = 1'b0;
    logic       sda_in, scl_in;
    logic       sda_drive_low, scl_drive_low;
    logic [4:0] cmd_bits;
    logic       start_seen, done_irq, wcol, bcol;
    logic [7:0] buf_data;

    int n_checks = 0;
    int n_fails  = 0;
    logic finished_all = 1'b0;

    always #10 clk = ~clk;  // 50 MHz

    // wired-AND with pull-ups, plus a second master that can pull the lines
    assign sda_in = !(sda_drive_low || inj_sda);
    assign scl_in = !(scl_drive_low || inj_scl);

    i2c_rs_top i_i2c_rs_top (
        .clk (clk), .rst_n (rst_n), .cmd_we (cmd_we), .cmd_wdata (cmd_wdata),
        .reload (reload), .bus_idle (bus_idle), .sda_in (sda_in), .scl_in (scl_in),
        .buf_we (buf_we), .buf_wdata (buf_wdata), .flag_clr (flag_clr),
        .sda_drive_low (sda_drive_low), .scl_drive_low (scl_drive_low),
        .cmd_bits (cmd_bits), .start_seen (start_seen), .done_irq (done_irq),
        .wcol (wcol), .bcol (bcol), .buf_data (buf_data)
    );

    function automatic int exp_scl_rel(input int n); return n + 3;     endfunction
    function automatic int exp_sda_low(input int n); return 2 * n + 5; endfunction
    function automatic int exp_done(input int n);    return 3 * n + 6; endfunction

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic pulse_clr();
        @(negedge clk); flag_clr = 1'b1;
        @(negedge clk); flag_clr = 1'b0;
    endtask

    // mode: 0 plain, 1 buffer write, 2 command write, 3 SDA held at SCL rise, 4 SCL pulled in setup
    task automatic run_rs(input int n, input int mode);
        int k;
        int k_rel;
        int k_sda;
        int k_end;
        logic st_at_sda;
        logic done_loop;
        logic [7:0] buf_before;
        k_rel = -1; k_sda = -1; k_end = -1; st_at_sda = 1'b0; done_loop = 1'b0;
        buf_before = '0;
        pulse_clr();
        reload = 7'(n);
        @(negedge clk); cmd_we = 1'b1; cmd_wdata = 5'b00010;
        @(negedge clk); cmd_we = 1'b0; k = 1;
        check("R2 scl driven low after accept", int'(scl_drive_low), 1);
        while (!done_loop && k < 2000) begin
            if (k == 2) check("R2 sda released after scl low", int'(sda_drive_low), 0);
            if (!scl_drive_low && k_rel < 0) k_rel = k;
            if (k >= 2 && sda_drive_low && k_sda < 0) begin
                k_sda = k; st_at_sda = start_seen;
            end
            if (done_irq || bcol) begin
                done_loop = 1'b1; k_end = k;
            end
            if (mode == 1 && k == 2) begin
                buf_before = buf_data; buf_we = 1'b1; buf_wdata = ~buf_data;
            end
            if (mode == 1 && k == 3) begin
                buf_we = 1'b0;
                check("R8 wcol on busy buffer write", int'(wcol), 1);
                check("R8 buffer unchanged", int'(buf_data), int'(buf_before));
            end
            if (mode == 2 && k == 2) begin
                cmd_we = 1'b1; cmd_wdata = 5'b11101;
            end
            if (mode == 2 && k == 3) begin
                cmd_we = 1'b0;
                check("R9 busy command write ignored", int'(cmd_bits), 5'b00010);
            end
            if (mode == 3 && k == k_rel) inj_sda = 1'b1;
            if (mode == 4 && k_rel > 0 && k == k_rel + 1) inj_scl = 1'b1;
            if (!done_loop) begin
                @(negedge clk); k++;
            end
        end
        inj_sda = 1'b0; inj_scl = 1'b0;
        if (mode <= 2) begin
            check("R3 scl release cycle", k_rel, exp_scl_rel(n));
            check("R4 sda low cycle", k_sda, exp_sda_low(n));
            check("R5 done cycle", k_end, exp_done(n));
            if (n == 0) check("R6 zero reload one-clock phases", k_end, 6);
            check("R5 request bit cleared", int'(cmd_bits[1]), 0);
            check("R5 sda stays low", int'(sda_drive_low), 1);
            check("R5 scl released", int'(scl_drive_low), 0);
            check("R7 no start before sda low", int'(st_at_sda), 0);
            check("R7 start seen", int'(start_seen), 1);
            check("R11 no collision", int'(bcol), 0);
        end else begin
            if (mode == 3) check("R10 collision at scl rise", k_end, exp_scl_rel(n) + 1);
            else           check("R11 collision in setup", k_end, exp_scl_rel(n) + 2);
            check("R11 bcol set", int'(bcol), 1);
            check("R11 no done", int'(done_irq), 0);
            check("R11 lines released", int'(sda_drive_low) + int'(scl_drive_low), 0);
            check("R11 request cleared", int'(cmd_bits[1]), 0);
            repeat (3) @(negedge clk);
            check("R11 bcol sticky", int'(bcol), 1);
            check("R11 idle after collision", int'(scl_drive_low), 0);
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!finished_all) begin
            n_checks++; n_fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

    initial begin : main
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset scl", int'(scl_drive_low), 0);
        check("R1 reset sda", int'(sda_drive_low), 0);
        check("R12 reset flags", int'({done_irq, wcol, bcol, start_seen}), 0);
        check("R9 reset cmd", int'(cmd_bits), 0);

        // R8: idle buffer write loads
        @(negedge clk); buf_we = 1'b1; buf_wdata = 8'hA5;
        @(negedge clk); buf_we = 1'b0;
        check("R8 idle buffer write", int'(buf_data), 8'hA5);
        check("R8 no wcol when idle", int'(wcol), 0);

        // R9: idle command write stores bits, no request
        @(negedge clk); cmd_we = 1'b1; cmd_wdata = 5'b10101;
        @(negedge clk); cmd_we = 1'b0;
        check("R9 idle command stored", int'(cmd_bits), 5'b10101);

        // R1: request while controller busy elsewhere
        bus_idle = 1'b0;
        @(negedge clk); cmd_we = 1'b1; cmd_wdata = 5'b00010;
        @(negedge clk); cmd_we = 1'b0;
        check("R1 refused scl", int'(scl_drive_low), 0);
        check("R1 refused request bit", int'(cmd_bits[1]), 0);
        repeat (4) @(negedge clk);
        check("R1 still idle", int'(scl_drive_low), 0);
        bus_idle = 1'b1;

        // directed corners
        run_rs(0, 0);
        run_rs(127, 0);
        run_rs(3, 1);
        run_rs(2, 2);
        run_rs(0, 3);
        run_rs(5, 4);

        // R12: clear
        pulse_clr();
        check("R12 flags cleared", int'({done_irq, wcol, bcol, start_seen}), 0);

        // constrained random
        for (int i = 0; i < 24; i++) begin
            run_rs(int'($urandom % 20), int'($urandom % 5));
        end

        finished_all = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule